// File: doc/BRIEF.md
# Digital audio receiver error concealment

This block follows the biphase decoder in a serial digital audio receiver. For each frame it gets a one-cycle strobe, a left and a right sample, a parity-good flag for each subframe, a flag that says whether the frame's preambles were well formed, and the sample-rate code. One clock after each strobe it presents concealed left and right samples, a sample-rate output code and an error flag. All outputs are registered.

Errors are handled in two tiers. A short run of bad parity on a channel repeats that channel's last good sample. A longer run mutes the channel. A missing or malformed preamble counts as loss of lock. Loss of lock mutes both channels, forgets the stored samples and shows a fixed "unknown" rate code. The error flag rises on any bad frame. It falls only after a parameterised number of consecutive clean frames. Because this hold is counted in frames, it lasts longer at low sample rates and shorter at high ones. With the default of 12288 frames it is roughly a quarter of a second at common rates.

Top module: `audio_err_conceal`

## Requirements
- R1: After reset, until the first frame arrives, both audio outputs are zero, `err_o` is 1 and `rate_out` holds the unknown code. The unknown code is the all-ones value of RATE_W bits.
- R2: For a frame with `preamble_ok`=1, a channel whose parity flag is 1 outputs that frame's input sample. The output appears on the cycle after the `frame_vld` strobe, and `out_vld` is 1 on that same single cycle.
- R3: With `preamble_ok`=1, the 1st through PAR_LIMIT-th consecutive bad-parity sample on a channel outputs that channel's last good sample. PAR_LIMIT defaults to 8. If no good sample has been seen since reset or the last lock loss, the output is zero.
- R4: From the (PAR_LIMIT+1)-th consecutive bad-parity sample on a channel onward, that channel outputs zero.
- R5: Each channel keeps its own run of bad-parity samples. A single good-parity sample on a channel ends that channel's run.
- R6: A frame with `preamble_ok`=0 drives both audio outputs to zero and `rate_out` to the unknown code. It also clears both runs and both stored last-good samples.
- R7: A frame with `preamble_ok`=1 and both parity flags 1 loads `rate_in` into `rate_out`. A frame with a parity error but a valid preamble leaves `rate_out` unchanged.
- R8: `err_o` is 1 on the cycle after any frame with a preamble fault or a parity error on either channel.
- R9: `err_o` falls with the output of the HOLD_FRAMES-th consecutive clean frame after the last bad frame (or after reset). Any bad frame during the hold restarts the count.
- R10: On cycles with `frame_vld`=0, all outputs keep their values whatever the other inputs do, and `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | One-cycle strobe marking a decoded frame |
| preamble_ok | input | 1 | Frame preambles detected and well formed |
| left_par_ok | input | 1 | Left subframe parity good |
| right_par_ok | input | 1 | Right subframe parity good |
| left_in | input | SAMPLE_W | Decoded left sample |
| right_in | input | SAMPLE_W | Decoded right sample |
| rate_in | input | RATE_W | Sample-rate code from the decoder |
| left_out | output | SAMPLE_W | Concealed left sample |
| right_out | output | SAMPLE_W | Concealed right sample |
| rate_out | output | RATE_W | Sample-rate output code, all ones when unknown |
| err_o | output | 1 | Error flag with recovery hold |
| out_vld | output | 1 | Outputs updated this cycle |

## Verification
The assertions assume that `frame_vld` is a single-cycle strobe with at least one idle cycle between frames. They also assume that the flags and samples are meaningful only on strobe cycles. The stimulus keeps to this by sending each frame as a one-cycle pulse followed by an idle cycle, and by scrambling the data inputs during idle cycles. Random phases switch between dense and sparse parity faults, so runs both shorter and longer than the mute threshold occur. Occasional preamble faults test lock loss, and quiet stretches let the recovery hold expire.

// File: rtl/aec_pkg.sv
package aec_pkg;
  // Index of each channel in the internal per-channel arrays
  localparam int CH_LEFT  = 0;
  localparam int CH_RIGHT = 1;
  localparam int N_CH     = 2;

  // Returns the all-ones rate code used when the rate is unknown
  function automatic int unsigned unk_rate(input int unsigned w);
    return (1 << w) - 1;
  endfunction
endpackage

// File: rtl/aec_chan_conceal.sv
module aec_chan_conceal #(
  parameter int SAMPLE_W  = 24,
  parameter int PAR_LIMIT = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stb,
  input  logic                lock_ok,
  input  logic                par_ok,
  input  logic [SAMPLE_W-1:0] smp_in,
  output logic [SAMPLE_W-1:0] smp_out
);
  localparam int CNT_W = $clog2(PAR_LIMIT + 2);
  localparam logic [CNT_W-1:0] RUN_SAT = CNT_W'(PAR_LIMIT + 1);
  localparam logic [CNT_W-1:0] RUN_LIM = CNT_W'(PAR_LIMIT);

  logic [CNT_W-1:0]    run_q;
  logic [SAMPLE_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      last_q  <= '0;
      smp_out <= '0;
    end else if (stb) begin
      if (!lock_ok) begin
        run_q   <= '0;
        last_q  <= '0;
        smp_out <= '0;
      end else if (par_ok) begin
        run_q   <= '0;
        last_q  <= smp_in;
        smp_out <= smp_in;
      end else begin
        if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
        // run_q counts earlier bad samples; this one is number run_q+1
        smp_out <= (run_q < RUN_LIM) ? last_q : '0;
      end
    end
  end

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    stb && lock_ok && par_ok |=> smp_out == $past(smp_in));
  // R4
  long_run_mute_chk: assert property (@(posedge clk) disable iff (rst)
    stb && lock_ok && !par_ok && run_q >= RUN_LIM |=> smp_out == '0);
  // R6
  lock_mute_chk: assert property (@(posedge clk) disable iff (rst)
    stb && !lock_ok |=> smp_out == '0 && run_q == '0);
  // R5
  run_cap_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_SAT);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(smp_out) && $stable(run_q));
endmodule

// File: rtl/aec_rate_track.sv
module aec_rate_track #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              lock_ok,
  input  logic              all_par_ok,
  input  logic [RATE_W-1:0] rate_in,
  output logic [RATE_W-1:0] rate_out
);
  localparam logic [RATE_W-1:0] RATE_UNK = RATE_W'(aec_pkg::unk_rate(RATE_W));

  always_ff @(posedge clk) begin
    if (rst)                      rate_out <= RATE_UNK;
    else if (stb && !lock_ok)     rate_out <= RATE_UNK;
    else if (stb && all_par_ok)   rate_out <= rate_in;
  end

  // R6
  unk_on_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    stb && !lock_ok |=> rate_out == RATE_UNK);
  // R7
  parity_keeps_rate_chk: assert property (@(posedge clk) disable iff (rst)
    stb && lock_ok && !all_par_ok |=> $stable(rate_out));
endmodule

// File: rtl/aec_recovery_hold.sv
module aec_recovery_hold #(
  parameter int HOLD_FRAMES = 12288
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic bad,
  output logic err_o
);
  localparam int HW = $clog2(HOLD_FRAMES + 1);
  localparam logic [HW-1:0] HOLD_END = HW'(HOLD_FRAMES);

  logic [HW-1:0] good_q;
  logic [HW-1:0] good_nx;

  always_comb begin
    good_nx = good_q;
    if (good_q != HOLD_END) good_nx = good_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      good_q <= '0;
      err_o  <= 1'b1;
    end else if (stb) begin
      if (bad) begin
        good_q <= '0;
        err_o  <= 1'b1;
      end else begin
        good_q <= good_nx;
        err_o  <= (good_nx != HOLD_END);
      end
    end
  end

  // R8
  err_on_bad_chk: assert property (@(posedge clk) disable iff (rst)
    stb && bad |=> err_o);
  // R9
  err_fall_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_o) |-> $past(stb) && !$past(bad));
  // R9
  hold_cap_chk: assert property (@(posedge clk) disable iff (rst)
    good_q <= HOLD_END);
endmodule

// File: rtl/audio_err_conceal.sv
module audio_err_conceal #(
  parameter int SAMPLE_W    = 24,
  parameter int RATE_W      = 4,
  parameter int PAR_LIMIT   = 8,
  parameter int HOLD_FRAMES = 12288
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_vld,
  input  logic                preamble_ok,
  input  logic                left_par_ok,
  input  logic                right_par_ok,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic [RATE_W-1:0]   rate_in,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic [RATE_W-1:0]   rate_out,
  output logic                err_o,
  output logic                out_vld
);
  import aec_pkg::*;

  logic [N_CH-1:0]               par_ok_v;
  logic [N_CH-1:0][SAMPLE_W-1:0] smp_in_v;
  logic [N_CH-1:0][SAMPLE_W-1:0] smp_out_v;
  logic                          frame_bad;

  assign par_ok_v[CH_LEFT]  = left_par_ok;
  assign par_ok_v[CH_RIGHT] = right_par_ok;
  assign smp_in_v[CH_LEFT]  = left_in;
  assign smp_in_v[CH_RIGHT] = right_in;
  assign left_out           = smp_out_v[CH_LEFT];
  assign right_out          = smp_out_v[CH_RIGHT];
  assign frame_bad          = !preamble_ok || !(&par_ok_v);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    aec_chan_conceal #(.SAMPLE_W(SAMPLE_W), .PAR_LIMIT(PAR_LIMIT)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .stb     (frame_vld),
      .lock_ok (preamble_ok),
      .par_ok  (par_ok_v[c]),
      .smp_in  (smp_in_v[c]),
      .smp_out (smp_out_v[c])
    );
  end

  aec_rate_track #(.RATE_W(RATE_W)) u_rate (
    .clk        (clk),
    .rst        (rst),
    .stb        (frame_vld),
    .lock_ok    (preamble_ok),
    .all_par_ok (&par_ok_v),
    .rate_in    (rate_in),
    .rate_out   (rate_out)
  );

  aec_recovery_hold #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .stb   (frame_vld),
    .bad   (frame_bad),
    .err_o (err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= frame_vld;
  end

  // R2
  out_vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld |=> out_vld);
  // R10
  out_vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_vld |=> !out_vld && $stable(err_o) && $stable(rate_out));
  // R6
  unlock_err_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld && !preamble_ok |=> err_o && left_out == '0 && right_out == '0);
endmodule

// File: tb/tb_audio_err_conceal.sv
`timescale 1ns/1ps
module tb_audio_err_conceal;
  localparam int SW   = 16;
  localparam int RW   = 4;
  localparam int LIM  = 8;
  localparam int HOLD = 20;
  localparam logic [RW-1:0] UNK = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_vld = 1'b0, preamble_ok = 1'b0, left_par_ok = 1'b0, right_par_ok = 1'b0;
  logic [SW-1:0] left_in = '0, right_in = '0;
  logic [RW-1:0] rate_in = '0;
  logic [SW-1:0] left_out, right_out;
  logic [RW-1:0] rate_out;
  logic err_o, out_vld;

  always #2.5 clk = ~clk;

  audio_err_conceal #(.SAMPLE_W(SW), .RATE_W(RW), .PAR_LIMIT(LIM), .HOLD_FRAMES(HOLD)) dut (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .preamble_ok(preamble_ok),
    .left_par_ok(left_par_ok), .right_par_ok(right_par_ok),
    .left_in(left_in), .right_in(right_in), .rate_in(rate_in),
    .left_out(left_out), .right_out(right_out), .rate_out(rate_out),
    .err_o(err_o), .out_vld(out_vld));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  int lc = 0, rc = 0, hold = 0;
  logic [SW-1:0] ll = '0, rl = '0, el = '0, er = '0;
  logic [RW-1:0] erate = UNK;
  logic eerr = 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string ch_tag(bit pre, bit ok, int cnt);
    if (!pre) return "R6";
    if (ok) return "R2";
    return (cnt <= LIM) ? "R3" : "R4";
  endfunction

  task automatic frame(bit pre, bit lp, bit rp, logic [SW-1:0] l, logic [SW-1:0] r, logic [RW-1:0] rt);
    bit bad = !pre || !lp || !rp;
    string lt, rtg;
    if (!pre) begin
      el = '0; er = '0; ll = '0; rl = '0; lc = 0; rc = 0; erate = UNK;
    end else begin
      if (lp) begin el = l; ll = l; lc = 0; end
      else begin lc = (lc < LIM + 1) ? lc + 1 : lc; el = (lc <= LIM) ? ll : '0; end
      if (rp) begin er = r; rl = r; rc = 0; end
      else begin rc = (rc < LIM + 1) ? rc + 1 : rc; er = (rc <= LIM) ? rl : '0; end
      if (lp && rp) erate = rt;
    end
    if (bad) begin hold = 0; eerr = 1'b1; end
    else begin if (hold < HOLD) hold++; eerr = (hold < HOLD); end
    lt = ch_tag(pre, lp, lc);
    rtg = ch_tag(pre, rp, rc);
    preamble_ok = pre; left_par_ok = lp; right_par_ok = rp;
    left_in = l; right_in = r; rate_in = rt; frame_vld = 1'b1;
    @(negedge clk);
    frame_vld = 1'b0;
    chk("R2 out_vld", 32'(out_vld), 32'd1);
    chk({lt, " left"}, 32'(left_out), 32'(el));
    chk({rtg, " right"}, 32'(right_out), 32'(er));
    chk(pre ? "R7 rate" : "R6 rate", 32'(rate_out), 32'(erate));
    chk(bad ? "R8 err" : "R9 err", 32'(err_o), 32'(eerr));
    @(negedge clk);
  endtask

  task automatic idle_scramble();
    preamble_ok = 1'($urandom); left_par_ok = 1'($urandom); right_par_ok = 1'($urandom);
    left_in = SW'($urandom); right_in = SW'($urandom); rate_in = RW'($urandom);
    @(negedge clk);
    chk("R10 out_vld", 32'(out_vld), 32'd0);
    chk("R10 left", 32'(left_out), 32'(el));
    chk("R10 right", 32'(right_out), 32'(er));
    chk("R10 rate", 32'(rate_out), 32'(erate));
    chk("R10 err", 32'(err_o), 32'(eerr));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 left", 32'(left_out), 32'd0);
    chk("R1 right", 32'(right_out), 32'd0);
    chk("R1 rate", 32'(rate_out), 32'(UNK));
    chk("R1 err", 32'(err_o), 32'd1);
    chk("R1 out_vld", 32'(out_vld), 32'd0);

    // R2 clean frames, R9 hold expiry after reset
    for (int i = 0; i < HOLD + 2; i++) frame(1, 1, 1, SW'(16'h100 + i), SW'(16'h200 + i), 4'h3);
    chk("R9 err low after hold", 32'(err_o), 32'd0);
    idle_scramble();

    // R3/R4 long left parity run, right stays good (R5 independence)
    for (int i = 0; i < LIM + 3; i++) begin
      frame(1, 0, 1, SW'($urandom), SW'(16'h300 + i), 4'h5);
      chk("R5 right independent", 32'(right_out), 32'(16'h300 + i));
    end
    // R5 one good sample ends the run
    frame(1, 1, 1, 16'hABCD, 16'h1111, 4'h6);
    frame(1, 0, 1, 16'h0, 16'h2222, 4'h6);
    chk("R5 run restarted", 32'(left_out), 32'hABCD);

    // R9 restart of hold by error midway
    for (int i = 0; i < HOLD / 2; i++) frame(1, 1, 1, SW'(i), SW'(i), 4'h2);
    frame(1, 1, 0, 16'h7, 16'h8, 4'h9);
    for (int i = 0; i < HOLD - 1; i++) frame(1, 1, 1, SW'(i), SW'(i), 4'h2);
    chk("R9 still held", 32'(err_o), 32'd1);
    frame(1, 1, 1, 16'h1, 16'h1, 4'h2);
    chk("R9 released", 32'(err_o), 32'd0);

    // R6 lock loss clears stored samples
    frame(0, 1, 1, 16'h5555, 16'h6666, 4'h7);
    frame(1, 0, 0, 16'h1, 16'h2, 4'h7);
    chk("R6 last cleared", 32'(left_out), 32'd0);
    idle_scramble();

    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      int dense = $urandom_range(0, 2);
      for (int i = 0; i < 40; i++) begin
        bit pre = ($urandom_range(0, 39) != 0);
        bit lp, rp;
        if (dense == 0)      begin lp = ($urandom_range(0, 7) == 0); rp = ($urandom_range(0, 3) != 0); end
        else if (dense == 1) begin lp = ($urandom_range(0, 5) != 0); rp = ($urandom_range(0, 5) != 0); end
        else                 begin lp = 1'b1; rp = 1'b1; pre = 1'b1; end
        frame(pre, lp, rp, SW'($urandom), SW'($urandom), RW'($urandom_range(0, 14)));
        if ($urandom_range(0, 9) == 0) idle_scramble();
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule